// File: doc/BRIEF.md
# Four-Phase Clock Generator with Reset Latch

This block turns a fast reference clock into four active-high clock phases of equal frequency. Each phase starts one quarter period after the previous one, and no two phases are ever high together. Every tick of an oscillator advances a one-hot ring by one position, so the tick rate is four times the phase frequency. The block also drives an inverted copy of every phase and a mirror of the tick that is in use.

The tick comes from one of two sources, picked by a select input. The first is an internal prescaler running on the reference. It gives one tick every reference cycle in the fast variant (overall division by 4) or one tick every four reference cycles in the legacy variant (overall division by 16). The second is an external oscillator input, which is synchronized and edge-detected. All logic is clocked by the reference, and ticks are one-cycle enables rather than derived clocks.

A reset latch samples an active-low reset request only at the trailing edge of the third phase. Its output serves as the active-low system reset for the logic that the phases drive.

Top module: `qphase_clkgen`

## Requirements
- R1: While `rst_n_i` is low, `phase_o` is 0, `phase_n_o` is all ones, `sys_rst_n_o` is 0 and the prescaler is cleared, so `osc_mirror_o` is 0 when the internal source is in legacy mode.
- R2: On each tick the ring advances one position: from the all-inactive state to `phase_o[0]`, then bit 0 to 1 to 2 to 3 and back to bit 0. Between ticks the phases hold.
- R3: At most one bit of `phase_o` is high in any cycle.
- R4: `phase_n_o` is always the bitwise inverse of `phase_o`.
- R5: With the internal source (`src_ext_i`=0) and `mode_fast_i`=0, a tick occurs every 4 reference cycles, so each phase repeats every 16 cycles.
- R6: With the internal source and `mode_fast_i`=1, a tick occurs every reference cycle, so each phase repeats every 4 cycles.
- R7: With `src_ext_i`=1, a tick occurs once per rising edge of `osc_ext_i`. The input passes two synchronizer flops, and the ring changes at the third rising reference edge after the input goes high. A level held high gives only one tick.
- R8: `osc_mirror_o` is high for exactly the cycles in which a tick from the selected source is present, and the ring moves at the clock edge that ends such a cycle.
- R9: `sys_rst_n_o` takes the value of `rstreq_n_i` at the clock edge where a tick ends `phase_o[2]`, and holds its value at every other edge.
- R10: At the first clock edge after `{src_ext_i, mode_fast_i}` differs from its registered value, the ring clears to all-inactive and the prescaler restarts. This restart overrides a tick in the same cycle, so the ring does not advance and `sys_rst_n_o` holds. The next tick asserts `phase_o[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| src_ext_i | input | 1 | 1 selects the external oscillator as tick source |
| mode_fast_i | input | 1 | 1 selects overall division by 4, 0 by 16 (internal source) |
| osc_ext_i | input | 1 | External oscillator, asynchronous |
| rstreq_n_i | input | 1 | Active-low reset request to be latched |
| phase_o | output | NPHASE | Non-overlapping active-high phases |
| phase_n_o | output | NPHASE | Inverted phases |
| osc_mirror_o | output | 1 | One-cycle pulse for each selected tick |
| sys_rst_n_o | output | 1 | Latched active-low system reset |

## Verification
Two events can fall in the same cycle: a source or mode restart, and a tick that ends the third phase. When both happen, the restart must win and the reset latch must not sample. The bench provokes this by stepping the external source until the third phase is active. It then sets the reset request opposite to the latched value and, in one cycle, switches to the fast internal source, whose prescaler ticks at once. The result is correct if the ring clears, the latch holds its old value and the following tick asserts the first phase. A behavioural reference model, compared every cycle, also covers every other source, mode and reset-request pattern.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  // Tick source selection as registered for restart detection
  typedef struct packed {
    logic ext;   // external oscillator drives the ring
    logic fast;  // short prescale ratio for the internal source
  } qpc_sel_t;

endpackage

// File: rtl/qpc_prescaler.sv
module qpc_prescaler #(
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic run_i,
  input  logic clear_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CW     = (MAXDIV > 1) ? $clog2(MAXDIV) : 1;
  localparam logic [CW-1:0] LIM_SLOW = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(FAST_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim;
  logic          at_lim;

  always_comb begin
    lim    = fast_i ? LIM_FAST : LIM_SLOW;
    at_lim = (cnt_q == lim);
    if (clear_i || !run_i) begin
      cnt_d = '0;
    end else if (at_lim) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = run_i & at_lim;

endmodule

// File: rtl/qpc_edge_sync.sv
module qpc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic en_i,
  input  logic async_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rise_o = en_i & sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/qpc_phase_ring.sv
module qpc_phase_ring #(
  parameter int NPHASE = 4
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              adv_i,
  input  logic              clear_i,
  output logic [NPHASE-1:0] ring_o
);
  logic [NPHASE-1:0] ring_q, ring_d;

  always_comb begin
    ring_d = ring_q;
    if (clear_i) begin
      ring_d = '0;
    end else if (adv_i) begin
      if (ring_q == '0) begin
        ring_d = NPHASE'(1);
      end else begin
        ring_d = {ring_q[NPHASE-2:0], ring_q[NPHASE-1]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ring_q <= '0;
    end else begin
      ring_q <= ring_d;
    end
  end

  assign ring_o = ring_q;

endmodule

// File: rtl/qpc_reset_latch.sv
module qpc_reset_latch (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sample_i,
  input  logic d_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = sample_i ? d_i : q_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      q_q <= 1'b0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/qphase_clkgen.sv
module qphase_clkgen #(
  parameter int NPHASE      = 4,
  parameter int SLOW_DIV    = 4,
  parameter int FAST_DIV    = 1,
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_IDX  = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              src_ext_i,
  input  logic              mode_fast_i,
  input  logic              osc_ext_i,
  input  logic              rstreq_n_i,
  output logic [NPHASE-1:0] phase_o,
  output logic [NPHASE-1:0] phase_n_o,
  output logic              osc_mirror_o,
  output logic              sys_rst_n_o
);
  import qpc_pkg::*;

  qpc_sel_t sel_now, sel_q;
  logic     sel_chg;
  logic     tick_int, tick_ext, tick;
  logic     adv;
  logic [NPHASE-1:0] ring;

  assign sel_now.ext  = src_ext_i;
  assign sel_now.fast = mode_fast_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_now;
    end
  end

  assign sel_chg = (sel_now != sel_q);

  qpc_prescaler #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV)
  ) i_pre (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .run_i   (~src_ext_i),
    .clear_i (sel_chg),
    .fast_i  (mode_fast_i),
    .tick_o  (tick_int)
  );

  qpc_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .en_i    (src_ext_i),
    .async_i (osc_ext_i),
    .rise_o  (tick_ext)
  );

  assign tick = tick_int | tick_ext;
  assign adv  = tick & ~sel_chg;

  qpc_phase_ring #(
    .NPHASE (NPHASE)
  ) i_ring (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .adv_i   (adv),
    .clear_i (sel_chg),
    .ring_o  (ring)
  );

  qpc_reset_latch i_latch (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .sample_i (adv & ring[SAMPLE_IDX]),
    .d_i      (rstreq_n_i),
    .q_o      (sys_rst_n_o)
  );

  assign phase_o      = ring;
  assign phase_n_o    = ~ring;
  assign osc_mirror_o = tick;

endmodule

// File: rtl/qphase_clkgen_chk.sv
module qphase_clkgen_chk #(
  parameter int NPHASE     = 4,
  parameter int SAMPLE_IDX = 2
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              src_ext_i,
  input logic              mode_fast_i,
  input logic              rstreq_n_i,
  input logic [NPHASE-1:0] phase_o,
  input logic              osc_mirror_o,
  input logic              sys_rst_n_o
);
  logic [1:0] sel_seen;
  logic       chg;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sel_seen <= 2'b00;
    end else begin
      sel_seen <= {src_ext_i, mode_fast_i};
    end
  end

  assign chg = ({src_ext_i, mode_fast_i} != sel_seen);

  // R3: phases never overlap
  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(phase_o));

  // R2: an active ring rotates by one on a tick
  p_rotate_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (osc_mirror_o && !chg && phase_o != '0) |=>
      phase_o == {$past(phase_o[NPHASE-2:0]), $past(phase_o[NPHASE-1])});

  // R2: from idle the first tick selects phase 0
  p_first_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (osc_mirror_o && !chg && phase_o == '0) |=> phase_o == NPHASE'(1));

  // R2: no tick, no movement
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!osc_mirror_o && !chg) |=> $stable(phase_o));

  // R6: fast internal source ticks every cycle
  p_fast_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!src_ext_i && mode_fast_i && !chg) |-> osc_mirror_o);

  // R9: latch takes the request when the sampled phase ends
  p_latch_take_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (osc_mirror_o && !chg && phase_o[SAMPLE_IDX]) |=> sys_rst_n_o == $past(rstreq_n_i));

  // R9 and R10: latch holds otherwise
  p_latch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!(osc_mirror_o && !chg && phase_o[SAMPLE_IDX])) |=> $stable(sys_rst_n_o));

  // R10: selection change clears the ring
  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    chg |=> phase_o == '0);

endmodule

bind qphase_clkgen qphase_clkgen_chk #(
  .NPHASE     (NPHASE),
  .SAMPLE_IDX (SAMPLE_IDX)
) i_chk (.*);

// File: tb/test_qphase_clkgen.sv
module test_qphase_clkgen;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, src_ext, mode_fast, osc_ext, ffd;
  logic [3:0] ph, ph_n;
  logic       mir, srst;
  logic       run;
  int         n_cmp = 0;
  int         n_bad = 0;

  qphase_clkgen i_qphase_clkgen (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .src_ext_i    (src_ext),
    .mode_fast_i  (mode_fast),
    .osc_ext_i    (osc_ext),
    .rstreq_n_i   (ffd),
    .phase_o      (ph),
    .phase_n_o    (ph_n),
    .osc_mirror_o (mir),
    .sys_rst_n_o  (srst)
  );

  // Behavioural reference state
  int m_cnt, m_ring, m_q, m_sel, m_s1, m_s2, m_s3;

  function automatic bit m_tick();
    if (src_ext) return (m_s2 == 1 && m_s3 == 0);
    return (m_cnt == (mode_fast ? 0 : 3));
  endfunction

  function automatic logic [3:0] m_phase();
    logic [3:0] v;
    v = 4'b0000;
    if (m_ring != 0) v[m_ring-1] = 1'b1;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ring = 0; m_q = 0; m_sel = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit t, chg;
      int now_sel;
      t       = m_tick();
      now_sel = (src_ext ? 2 : 0) + (mode_fast ? 1 : 0);
      chg     = (now_sel != m_sel);
      m_sel   = now_sel;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = osc_ext ? 1 : 0;
      if (chg) begin
        m_cnt = 0; m_ring = 0;
      end else begin
        if (src_ext) m_cnt = 0;
        else if (m_cnt == (mode_fast ? 0 : 3)) m_cnt = 0;
        else m_cnt = m_cnt + 1;
        if (t) begin
          if (m_ring == 3) m_q = ffd ? 1 : 0;
          m_ring = (m_ring == 0 || m_ring == 4) ? 1 : m_ring + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && run) begin
      logic [3:0] ep, epn;
      ep  = m_phase();
      epn = ~ep;
      chk("R2 phases vs model", {28'd0, ph}, {28'd0, ep});
      chk("R4 inverted phases", {28'd0, ph_n}, {28'd0, epn});
      chk("R8 tick mirror", {31'd0, mir}, {31'd0, m_tick()});
      chk("R9 reset latch", {31'd0, srst}, 32'(m_q));
      chk("R3 at most one phase", 32'($countones(ph)), ($countones(ph) <= 1) ? 32'($countones(ph)) : 32'd1);
    end
  end

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic period(output int p);
    logic prev;
    int k;
    prev = ph[0]; k = 0;
    while (!(ph[0] && !prev) && k < 200) begin prev = ph[0]; cyc(); k++; end
    p = 0;
    do begin prev = ph[0]; cyc(); p++; end while (!(ph[0] && !prev) && p < 200);
  endtask

  initial begin
    int p;
    logic held;
    run = 1'b0; rst_n = 1'b0; src_ext = 1'b0; mode_fast = 1'b0;
    osc_ext = 1'b0; ffd = 1'b1;
    repeat (3) cyc();
    chk("R1 phases in reset", {28'd0, ph}, 32'd0);
    chk("R1 inverted in reset", {28'd0, ph_n}, 32'hf);
    chk("R1 latch in reset", {31'd0, srst}, 32'd0);
    chk("R1 mirror in reset", {31'd0, mir}, 32'd0);
    rst_n = 1'b1; run = 1'b1;

    // Legacy internal division
    repeat (10) cyc();
    period(p);
    chk("R5 phase period slow", 32'(p), 32'd16);
    ffd = 1'b0; repeat (20) cyc();
    chk("R9 low request latched", {31'd0, srst}, 32'd0);
    ffd = 1'b1; repeat (20) cyc();
    chk("R9 high request latched", {31'd0, srst}, 32'd1);

    // Switch to fast internal division
    mode_fast = 1'b1; cyc();
    chk("R10 ring cleared on mode change", {28'd0, ph}, 32'd0);
    cyc();
    chk("R10 first phase after restart", {28'd0, ph}, 32'd1);
    period(p);
    chk("R6 phase period fast", 32'(p), 32'd4);
    for (int i = 0; i < 60; i++) begin
      ffd = ((i % 5) < 2) ? 1'b0 : 1'b1;
      cyc();
    end
    ffd = 1'b1;

    // External source
    src_ext = 1'b1; mode_fast = 1'b0; cyc();
    chk("R10 ring cleared on source change", {28'd0, ph}, 32'd0);
    repeat (5) cyc();
    chk("R7 no edge no tick", {28'd0, ph}, 32'd0);
    osc_ext = 1'b1; cyc();
    chk("R7 latency edge 1", {28'd0, ph}, 32'd0);
    cyc();
    chk("R7 latency edge 2", {28'd0, ph}, 32'd0);
    cyc();
    chk("R7 advance at edge 3", {28'd0, ph}, 32'd1);
    repeat (10) cyc();
    chk("R7 held level ticks once", {28'd0, ph}, 32'd1);
    osc_ext = 1'b0; repeat (2) cyc();
    for (int i = 0; i < 30; i++) begin
      osc_ext = 1'b1; repeat ((i % 3) + 1) cyc();
      osc_ext = 1'b0; repeat ((i % 4) + 1) cyc();
      ffd = (i % 7 < 3) ? 1'b0 : 1'b1;
    end
    ffd = 1'b1; repeat (4) cyc();

    // Restart colliding with a tick that ends the third phase
    for (int g = 0; g < 20 && ph != 4'b0100; g++) begin
      osc_ext = 1'b1; repeat (2) cyc();
      osc_ext = 1'b0; repeat (3) cyc();
    end
    chk("R10 ring parked on third phase", {28'd0, ph}, 32'h4);
    held = srst;
    ffd = ~srst;
    src_ext = 1'b0; mode_fast = 1'b1;
    cyc();
    chk("R10 restart beats tick", {28'd0, ph}, 32'd0);
    chk("R10 latch holds on restart", {31'd0, srst}, {31'd0, held});
    cyc();
    chk("R10 first phase after collision", {28'd0, ph}, 32'd1);
    repeat (12) cyc();

    // Mid-run reset
    rst_n = 1'b0; cyc();
    chk("R1 phases after reset", {28'd0, ph}, 32'd0);
    chk("R1 latch after reset", {31'd0, srst}, 32'd0);
    src_ext = 1'b0; mode_fast = 1'b0; cyc();
    rst_n = 1'b1;
    repeat (40) cyc();
    report();
  end
endmodule